// File: doc/BRIEF.md
# Asynchronous Strobe/Acknowledge Bus Master

This block runs single read or write transfers on a 16-bit asynchronous bus on behalf of a processor core. The core offers a request with a word address, a direction, per-byte lane enables, write data and a 3-bit cycle-class code. The block then sequences the address strobe, the lane strobes, the direction line and the data-bus enable through eight half-clock phases, P0 to P7. In this design one `clk` period is one half of a bus clock. The block waits for the slave to acknowledge and hands back a response that carries the read data and an error flag.

The slave acknowledge input is sampled at the end of phase P4. If the acknowledge is not present, the block inserts wait states in pairs of half-clocks and samples again after each pair. A bus-error input that is seen at a sample point, with no acknowledge, ends the transfer without taking data. Requests enter over a valid/ready handshake. `req_ready` is low while a transfer or an unaccepted response is in flight. The response leaves over a valid/ready handshake, and its payload stays frozen until the core accepts it, so the core can apply back-pressure for as long as it needs.

Top module: `hsb_master`

## Requirements
- R1: `req_ready` is high only while the block is idle with no response pending and both `bus_dtack_n` and `bus_berr_n` are high. A slave that keeps its acknowledge asserted after the strobe is released therefore delays the next transfer.
- R2: From phase P1 onward, `bus_addr` carries request address bits 23:1 and `bus_fc` carries the request code. Both hold their values until P0 of the following transfer.
- R3: On a read, `bus_as_n` and every enabled lane strobe go low in P2 and stay low through P6 and any wait states. All of them return high together in P7. `bus_ds_n[1]` enables data bits 15:8 and `bus_ds_n[0]` enables bits 7:0. A lane whose enable is 0 never goes low.
- R4: On a write, `bus_as_n` goes low in P2 while `bus_rw_n` is still high. `bus_rw_n` is low and `bus_doe` is high from P3 through P7. The enabled lane strobes are low from P4 through P6 and any wait states. After P7, `bus_rw_n` is high and `bus_doe` is low.
- R5: The acknowledge is sampled at the end of P4. With no wait, a transfer occupies 8 clocks from the accepting edge to the start of the response. Each missed sample adds 2 clocks before the next sample.
- R6: A successful read returns `bus_din` as it was at the end of P6, masked so that disabled lanes read as zero. A write returns zero data.
- R7: If `bus_berr_n` is low and `bus_dtack_n` is high at a sample point, the transfer ends with `rsp_err`=1 and zero data. If both are low at the same sample point, the acknowledge wins and `rsp_err`=0.
- R8: `rsp_valid` stays high, with `rsp_rdata` and `rsp_err` stable, until a clock edge where `rsp_ready` is high. No request is accepted before that edge.
- R9: After reset, all strobes are high, `bus_rw_n` is high, `bus_doe` is low and `rsp_valid` is low.
- R10: In P0 of every transfer, `bus_as_n` and all lane strobes are high, `bus_rw_n` is high and `bus_doe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-bus-clock rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | 24 | Byte address (bit 0 ignored) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Lane enables, bit 1 = data 15:8 |
| req_wdata | input | 16 | Write data |
| req_fc | input | 3 | Cycle-class code |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| rsp_err | output | 1 | Transfer ended by bus error |
| bus_addr | output | 23 | Word address bits 23:1 |
| bus_fc | output | 3 | Cycle-class code on the bus |
| bus_rw_n | output | 1 | High = read, low = write |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_ds_n | output | 2 | Lane strobes, active low |
| bus_dout | output | 16 | Write data to the bus |
| bus_doe | output | 1 | Data bus drive enable |
| bus_din | input | 16 | Read data from the bus |
| bus_dtack_n | input | 1 | Slave acknowledge, active low |
| bus_berr_n | input | 1 | Bus error, active low |

## Verification
The hardest state to reach from the ports is a slave that holds its acknowledge low after the strobe goes high. At that moment a finished response and a blocked next request meet. The bench's slave model has a programmable release delay to create this case, and a programmable acknowledge latency that is swept from 0 to 6 half-clocks, so that zero, one and two wait pairs all occur for every word of a 16-word window. Error endings, simultaneous acknowledge and error, and long response back-pressure each come from dedicated slave modes that are switched on per transfer.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
  typedef enum logic [3:0] {
    ST_IDLE = 4'd0,
    ST_P0   = 4'd1,
    ST_P1   = 4'd2,
    ST_P2   = 4'd3,
    ST_P3   = 4'd4,
    ST_P4   = 4'd5,
    ST_P5   = 4'd6,
    ST_P6   = 4'd7,
    ST_P7   = 4'd8,
    ST_WA   = 4'd9,
    ST_WB   = 4'd10,
    ST_RESP = 4'd11
  } hsb_state_e;
endpackage

// File: rtl/hsb_seq.sv
module hsb_seq
  import hsb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       dtack_n,
  input  logic       berr_n,
  input  logic       rsp_ready,
  output hsb_state_e state,
  output logic       err
);
  hsb_state_e nxt;
  logic       at_sample;

  assign at_sample = (state == ST_P4) || (state == ST_WB);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (start) nxt = ST_P0;
      ST_P0:   nxt = ST_P1;
      ST_P1:   nxt = ST_P2;
      ST_P2:   nxt = ST_P3;
      ST_P3:   nxt = ST_P4;
      ST_P4, ST_WB: begin
        if (!dtack_n || !berr_n) nxt = ST_P5;
        else                     nxt = ST_WA;
      end
      ST_WA:   nxt = ST_WB;
      ST_P5:   nxt = ST_P6;
      ST_P6:   nxt = ST_P7;
      ST_P7:   nxt = ST_RESP;
      ST_RESP: if (rsp_ready) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      err   <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_P0)
        err <= 1'b0;
      else if (at_sample && dtack_n && !berr_n)
        err <= 1'b1;
    end
  end

  p_ack_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (at_sample && !dtack_n) |=> (state == ST_P5));
  p_wait_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (at_sample && dtack_n && berr_n) |=> (state == ST_WA));
  p_berr_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (at_sample && dtack_n && !berr_n) |=> (err && state == ST_P5));
endmodule

// File: rtl/hsb_strobes.sv
module hsb_strobes
  import hsb_pkg::*;
#(
  parameter int LANES = 2
) (
  input  hsb_state_e       state,
  input  logic             is_write,
  input  logic [LANES-1:0] be,
  output logic             as_n,
  output logic [LANES-1:0] ds_n,
  output logic             rw_n,
  output logic             doe
);
  logic as_win, wr_win, ds_win;

  always_comb begin
    as_win = state inside {ST_P2, ST_P3, ST_P4, ST_WA, ST_WB, ST_P5, ST_P6};
    wr_win = is_write &&
             (state inside {ST_P3, ST_P4, ST_WA, ST_WB, ST_P5, ST_P6, ST_P7});
    ds_win = is_write ? (state inside {ST_P4, ST_WA, ST_WB, ST_P5, ST_P6})
                      : as_win;
  end

  assign as_n = !as_win;
  assign rw_n = !wr_win;
  assign doe  = wr_win;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign ds_n[g] = !(ds_win && be[g]);
  end
endmodule

// File: rtl/hsb_master.sv
module hsb_master
  import hsb_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int FC_W   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                req_write,
  input  logic [DATA_W/8-1:0] req_be,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [FC_W-1:0]     req_fc,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                rsp_err,
  output logic [ADDR_W-2:0]   bus_addr,
  output logic [FC_W-1:0]     bus_fc,
  output logic                bus_rw_n,
  output logic                bus_as_n,
  output logic [DATA_W/8-1:0] bus_ds_n,
  output logic [DATA_W-1:0]   bus_dout,
  output logic                bus_doe,
  input  logic [DATA_W-1:0]   bus_din,
  input  logic                bus_dtack_n,
  input  logic                bus_berr_n
);
  localparam int LANES = DATA_W / 8;

  hsb_state_e           state;
  logic                 err;
  logic                 start;
  logic [ADDR_W-1:0]    addr_q;
  logic [FC_W-1:0]      fc_q;
  logic                 wr_q;
  logic [LANES-1:0]     be_q;
  logic [DATA_W-1:0]    wdata_q;
  logic [DATA_W-1:0]    rdata_q;
  logic [DATA_W-1:0]    lane_mask;

  assign req_ready = (state == ST_IDLE) && bus_dtack_n && bus_berr_n;
  assign start     = req_valid && req_ready;

  hsb_seq i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .dtack_n   (bus_dtack_n),
    .berr_n    (bus_berr_n),
    .rsp_ready (rsp_ready),
    .state     (state),
    .err       (err)
  );

  hsb_strobes #(.LANES(LANES)) i_strobes (
    .state    (state),
    .is_write (wr_q),
    .be       (be_q),
    .as_n     (bus_as_n),
    .ds_n     (bus_ds_n),
    .rw_n     (bus_rw_n),
    .doe      (bus_doe)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_mask
    assign lane_mask[g*8 +: 8] = {8{be_q[g]}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      fc_q     <= '0;
      wr_q     <= 1'b0;
      be_q     <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      bus_addr <= '0;
      bus_fc   <= '0;
    end else begin
      if (start) begin
        addr_q  <= req_addr;
        fc_q    <= req_fc;
        wr_q    <= req_write;
        be_q    <= req_be;
        wdata_q <= req_wdata;
      end
      if (state == ST_P0) begin
        bus_addr <= addr_q[ADDR_W-1:1];
        bus_fc   <= fc_q;
        rdata_q  <= '0;
      end else if (state == ST_P6 && !err && !wr_q) begin
        rdata_q  <= bus_din & lane_mask;
      end
    end
  end

  assign bus_dout  = wdata_q;
  assign rsp_valid = (state == ST_RESP);
  assign rsp_rdata = rdata_q;
  assign rsp_err   = err;

  p_lane_nest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ds_n != '1) |-> !bus_as_n);
  p_drive_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> !bus_rw_n);
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_as_n |=> (bus_as_n || ($stable(bus_addr) && $stable(bus_fc))));
  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));
  p_idle_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (bus_as_n && bus_rw_n && !bus_doe && bus_ds_n == '1));
  p_start_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (bus_dtack_n && !rsp_valid));
endmodule

// File: tb/test_hsb_master.sv
module test_hsb_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0;
  logic [2:0]  req_fc = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [15:0] rsp_rdata;
  logic        rsp_err;
  logic [22:0] bus_addr;
  logic [2:0]  bus_fc;
  logic        bus_rw_n, bus_as_n, bus_doe;
  logic [1:0]  bus_ds_n;
  logic [15:0] bus_dout;
  logic [15:0] bus_din = '0;
  logic        bus_dtack_n = 1'b1;
  logic        bus_berr_n = 1'b1;

  int n_chk = 0;
  int n_err = 0;
  int ticks = 0;

  // slave model controls
  int ack_k = 1;
  int slv_mode = 0;   // 0 acknowledge, 1 bus error, 2 both at once
  int rel_delay = 0;
  int as_cnt = 0;
  int rel_cnt = 0;
  logic [15:0] smem [16];
  logic [15:0] emem [16];

  hsb_master i_hsb_master (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_be(req_be), .req_wdata(req_wdata),
    .req_fc(req_fc), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .bus_addr(bus_addr),
    .bus_fc(bus_fc), .bus_rw_n(bus_rw_n), .bus_as_n(bus_as_n),
    .bus_ds_n(bus_ds_n), .bus_dout(bus_dout), .bus_doe(bus_doe),
    .bus_din(bus_din), .bus_dtack_n(bus_dtack_n), .bus_berr_n(bus_berr_n)
  );

  always #10 clk = ~clk;

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    ticks++;
    if (ticks > 150000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=<150000", ticks);
      finish_run();
    end
  end

  // slave: acknowledge latency in half-clocks, release delay after strobe
  always @(negedge clk) begin
    if (!bus_as_n) begin
      as_cnt++;
      rel_cnt = 0;
      if (as_cnt >= ack_k) begin
        if (slv_mode != 1) bus_dtack_n = 1'b0;
        if (slv_mode != 0) bus_berr_n = 1'b0;
      end
      if (!bus_rw_n && !bus_dtack_n) begin
        if (!bus_ds_n[1]) smem[bus_addr[3:0]][15:8] = bus_dout[15:8];
        if (!bus_ds_n[0]) smem[bus_addr[3:0]][7:0]  = bus_dout[7:0];
      end
    end else begin
      as_cnt = 0;
      if (!bus_dtack_n || !bus_berr_n) begin
        rel_cnt++;
        if (rel_cnt > rel_delay) begin
          bus_dtack_n = 1'b1;
          bus_berr_n  = 1'b1;
        end
      end
    end
    bus_din = smem[bus_addr[3:0]];
  end

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mask_of(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  task automatic run_xfer(input bit wr, input int widx, input logic [1:0] be,
                          input logic [15:0] wd, input logic [2:0] fc,
                          input int k, input int mode, input int hold);
    int cnt = 0;
    int guard = 0;
    int c;
    int waits;
    bit got = 0;
    logic last_as = 1'b1;
    logic last_rw = 1'b1;
    logic [1:0] last_ds = 2'b11;
    logic [23:0] a;
    logic [15:0] exp_d;
    logic [15:0] held;
    a = {4'hA, 15'd0, widx[3:0], 1'b0};
    ack_k = k;
    slv_mode = mode;
    while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
    req_addr = a; req_write = wr; req_be = be; req_wdata = wd; req_fc = fc;
    req_valid = 1'b1;
    while (!got && cnt < 200) begin
      @(negedge clk);
      cnt++;
      if (cnt == 1) begin
        req_valid = 1'b0;
        chk(bus_as_n && bus_ds_n == 2'b11 && bus_rw_n && !bus_doe,
            "R10 phase P0 idle strobes", {bus_as_n, bus_ds_n, bus_rw_n, bus_doe}, 5'b11110);
      end
      if (cnt == 2) begin
        chk(bus_addr == a[23:1], "R2 word address", 32'(bus_addr), 32'(a[23:1]));
        chk(bus_fc == fc, "R2 cycle code", 32'(bus_fc), 32'(fc));
      end
      if (cnt == 3) begin
        chk(!bus_as_n, "R3 address strobe in P2", 32'(bus_as_n), 0);
        if (!wr) chk(bus_ds_n == ~be, "R3 read lanes in P2", 32'(bus_ds_n), 32'(~be));
        else chk(bus_ds_n == 2'b11 && bus_rw_n, "R4 write lanes/dir in P2",
                 {bus_ds_n, bus_rw_n}, 3'b111);
      end
      if (cnt == 4 && wr)
        chk(!bus_rw_n && bus_doe, "R4 write dir and drive in P3", {bus_rw_n, bus_doe}, 2'b01);
      if (cnt == 5 && wr)
        chk(bus_ds_n == ~be, "R4 write lanes in P4", 32'(bus_ds_n), 32'(~be));
      if (rsp_valid) got = 1;
      else begin last_as = bus_as_n; last_ds = bus_ds_n; last_rw = bus_rw_n; end
    end
    c = (k < 1) ? 1 : k;
    waits = (c <= 3) ? 0 : (c - 2) / 2;
    chk(cnt == 9 + 2 * waits, "R5 transfer length", cnt, 9 + 2 * waits);
    chk(last_as && last_ds == 2'b11, "R3 strobes released in P7", {last_as, last_ds}, 3'b111);
    if (wr) chk(!last_rw, "R4 write dir held in P7", 32'(last_rw), 0);
    chk(bus_rw_n && !bus_doe, "R4 dir and drive after P7", {bus_rw_n, bus_doe}, 2'b10);
    chk(rsp_err == (mode == 1), "R7 error flag", 32'(rsp_err), 32'(mode == 1));
    if (wr || mode == 1) exp_d = '0;
    else exp_d = emem[widx] & mask_of(be);
    chk(rsp_rdata == exp_d, "R6 R7 response data", 32'(rsp_rdata), 32'(exp_d));
    if (wr && mode != 1) begin
      if (be[1]) emem[widx][15:8] = wd[15:8];
      if (be[0]) emem[widx][7:0]  = wd[7:0];
    end
    held = rsp_rdata;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_rdata == held && !req_ready, "R8 response held",
          {rsp_valid, req_ready}, 2'b10);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid, "R8 response taken", 32'(rsp_valid), 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      smem[i] = 16'(i * 16'h1111 + 16'h0203);
      emem[i] = smem[i];
    end
    repeat (3) @(negedge clk);
    chk(bus_as_n && bus_ds_n == 2'b11 && bus_rw_n && !bus_doe && !rsp_valid,
        "R9 reset outputs", {bus_as_n, bus_ds_n, bus_rw_n, bus_doe, rsp_valid}, 6'b111100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R9 R1 idle after reset", {req_ready, rsp_valid}, 2'b10);

    // sweep acknowledge latency, every word, writes then reads
    for (int k = 0; k <= 6; k++) begin
      for (int w = 0; w < 16; w++)
        run_xfer(1'b1, w, 2'((w + k) % 3 + 1), 16'(w * 16'h0731 + k * 16'h1F05),
                 3'(w), k, 0, 0);
      for (int w = 0; w < 16; w++)
        run_xfer(1'b0, w, 2'((w + 2 * k) % 3 + 1), 16'h0, 3'(7 - w % 8), k, 0, 0);
    end

    // bus error on read and on write, memory untouched afterwards
    run_xfer(1'b0, 3, 2'b11, 16'h0, 3'd5, 2, 1, 0);
    run_xfer(1'b1, 4, 2'b11, 16'hDEAD, 3'd1, 5, 1, 0);
    run_xfer(1'b0, 4, 2'b11, 16'h0, 3'd5, 1, 0, 0);
    // acknowledge and error together: acknowledge wins
    run_xfer(1'b0, 6, 2'b10, 16'h0, 3'd2, 3, 2, 0);
    // response back-pressure
    run_xfer(1'b0, 9, 2'b01, 16'h0, 3'd6, 4, 0, 5);

    // late acknowledge release blocks the next request (R1)
    rel_delay = 6;
    run_xfer(1'b0, 12, 2'b11, 16'h0, 3'd1, 1, 0, 0);
    chk(!req_ready && !bus_dtack_n, "R1 blocked while acknowledge held",
        {req_ready, bus_dtack_n}, 2'b00);
    for (int g = 0; g < 20 && !req_ready; g++) begin
      chk(!bus_dtack_n, "R1 ready only after release", 32'(bus_dtack_n), 0);
      @(negedge clk);
    end
    chk(req_ready && bus_dtack_n, "R1 ready after release", {req_ready, bus_dtack_n}, 2'b11);
    rel_delay = 0;
    run_xfer(1'b0, 12, 2'b11, 16'h0, 3'd1, 1, 0, 0);

    finish_run();
  end
endmodule